// File: doc/BRIEF.md
# Length-Bucket Match Fingerprint Accumulator

This block sits behind the last, slowest filter of a multi-stage string matcher. Only packets that survived the cheaper filters before it arrive here. On each accepted beat it receives up to eight match reports in parallel, one from each hash table lane. Every report carries a valid bit and a match length. The block sorts each valid report into one of sixteen length buckets. It sets that bucket's bit in a 16-bit vector and ORs the vectors of every beat of the packet together.

The result is a compact per-packet fingerprint. It shows which match lengths occurred anywhere in the packet. Downstream logic uses it to decide which deeper checks are worth running. The fingerprint is presented on the beat that closes the packet, under a ready/valid handshake, and the accumulator clears once that beat is taken.

Top module: `lbfp_acc`

## Requirements
- R1: After reset the accumulated state is empty. The first packet yields only the buckets of its own beats, even if its first beat carries no start flag. With no input valid, `fp_valid` is 0.
- R2: A valid report whose length L is 0 to 15 sets fingerprint bit L (bit 0 is the least significant bit).
- R3: A valid report whose length is 16 or more sets bit 15 only.
- R4: A lane whose valid bit is 0 adds nothing to the fingerprint, whatever its length field holds.
- R5: The fingerprint is the bitwise OR of the bucket bits of all valid reports on all accepted beats of the packet, including the closing beat.
- R6: A beat with `in_sop` = 1 discards whatever was accumulated before it. The packet then starts from that beat alone.
- R7: `fp_valid` is 1 exactly when `in_valid` and `in_eop` are both 1. On all other cycles it is 0.
- R8: While a closing beat is presented and `fp_ready` is 0, `in_ready` is 0 and the beat is not consumed. The accumulated state is kept, so the fingerprint shown later includes all earlier beats.
- R9: Once a closing beat is accepted, the next packet starts from an empty state, even if its first beat lacks `in_sop`.
- R10: A packet in which no lane is ever valid yields an all-zero fingerprint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A beat of match reports is presented |
| in_ready | output | 1 | The block takes the presented beat at the clock edge |
| in_sop | input | 1 | The beat opens a packet |
| in_eop | input | 1 | The beat closes a packet |
| tup_vld | input | LANES | Per-lane report valid bits |
| tup_len | input | LANES*LEN_W | Per-lane match lengths, lane i at bits [i*LEN_W +: LEN_W] |
| fp_valid | output | 1 | A fingerprint is offered |
| fp_ready | input | 1 | The consumer takes the fingerprint |
| fp_data | output | 16 | Bucket fingerprint of the packet so far, including the current beat |

## Verification
The hardest situation to reach is a closing beat that is refused while earlier beats of the same packet are still held. A fault that clears or double-counts state during the stall only shows up if those earlier beats carry buckets the closing beat lacks. The stimulus therefore builds packets whose middle beats hold buckets absent from the last beat. It holds `fp_ready` low for several cycles on that last beat and then checks the full OR when the beat is finally accepted. A second sequence asserts reset in the middle of a packet and then closes the packet without a start flag, to show that no stale buckets survive.

// File: rtl/lbfp_pkg.sv
package lbfp_pkg;
  localparam int BKT_N  = 16;
  localparam int BKT_IW = $clog2(BKT_N);
  typedef logic [BKT_N-1:0] bkt_vec_t;
endpackage

// File: rtl/lbfp_lane_dec.sv
module lbfp_lane_dec
  import lbfp_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             vld,
  input  logic [LEN_W-1:0] len,
  output bkt_vec_t         vec
);
  localparam logic [LEN_W-1:0] SAT_LEN = LEN_W'(BKT_N - 1);

  always_comb begin
    vec = '0;
    if (vld) begin
      if (len >= SAT_LEN) vec[BKT_N-1] = 1'b1;
      else                vec[len[BKT_IW-1:0]] = 1'b1;
    end
  end
endmodule

// File: rtl/lbfp_or_tree.sv
module lbfp_or_tree
  import lbfp_pkg::*;
#(
  parameter int LANES = 8
) (
  input  bkt_vec_t vecs [LANES],
  output bkt_vec_t merged
);
  bkt_vec_t part [LANES+1];

  assign part[0] = '0;
  for (genvar i = 0; i < LANES; i++) begin : g_chain
    assign part[i+1] = part[i] | vecs[i];
  end
  assign merged = part[LANES];
endmodule

// File: rtl/lbfp_acc.sv
module lbfp_acc
  import lbfp_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LEN_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_sop,
  input  logic                   in_eop,
  input  logic [LANES-1:0]       tup_vld,
  input  logic [LANES*LEN_W-1:0] tup_len,
  output logic                   fp_valid,
  input  logic                   fp_ready,
  output logic [BKT_N-1:0]       fp_data
);
  bkt_vec_t lane_vec [LANES];
  bkt_vec_t beat_vec;
  bkt_vec_t acc_q, acc_d, base;
  logic     take, acc_en;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lbfp_lane_dec #(.LEN_W(LEN_W)) u_dec (
      .vld (tup_vld[i]),
      .len (tup_len[i*LEN_W +: LEN_W]),
      .vec (lane_vec[i])
    );
  end

  lbfp_or_tree #(.LANES(LANES)) u_tree (
    .vecs   (lane_vec),
    .merged (beat_vec)
  );

  always_comb begin
    in_ready = !in_eop || fp_ready;
    take     = in_valid && in_ready;
    base     = in_sop ? '0 : acc_q;
    fp_data  = base | beat_vec;
    fp_valid = in_valid && in_eop;
    acc_en   = take;
    acc_d    = in_eop ? '0 : fp_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end
endmodule

// File: rtl/lbfp_acc_chk.sv
module lbfp_acc_chk
  import lbfp_pkg::*;
#(
  parameter int LANES = 8,
  parameter int LEN_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   in_sop,
  input logic                   in_eop,
  input logic [LANES-1:0]       tup_vld,
  input logic [LANES*LEN_W-1:0] tup_len,
  input logic                   fp_valid,
  input logic                   fp_ready,
  input logic [BKT_N-1:0]       fp_data
);
  logic [BKT_N-1:0] ref_beat;

  always_comb begin
    ref_beat = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int b = 0; b < BKT_N; b++) begin
        if (tup_vld[l]) begin
          if (b == BKT_N - 1) begin
            if (tup_len[l*LEN_W +: LEN_W] >= LEN_W'(b)) ref_beat[b] = 1'b1;
          end else if (tup_len[l*LEN_W +: LEN_W] == LEN_W'(b)) begin
            ref_beat[b] = 1'b1;
          end
        end
      end
    end
  end

  assert_beat_covered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_data & ref_beat) == ref_beat);

  assert_sop_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_sop |-> fp_data == ref_beat);

  assert_empty_packet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sop && tup_vld == '0) |-> fp_data == '0);

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eop && !fp_ready) |-> !in_ready);

  assert_clear_after_eop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_valid && fp_ready) |=> fp_data == ref_beat);

  assert_accumulate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_eop) |=>
      (in_sop || (fp_data & $past(fp_data)) == $past(fp_data)));
endmodule

bind lbfp_acc lbfp_acc_chk #(.LANES(LANES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sop(in_sop), .in_eop(in_eop), .tup_vld(tup_vld), .tup_len(tup_len),
  .fp_valid(fp_valid), .fp_ready(fp_ready), .fp_data(fp_data)
);

// File: tb/lbfp_acc_test.sv
`timescale 1ns/1ps
module lbfp_acc_test;
  localparam int LANES = 8;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, in_sop, in_eop, fp_valid, fp_ready;
  logic [LANES-1:0]       tup_vld;
  logic [LANES*LEN_W-1:0] tup_len;
  logic [15:0]            fp_data;

  int total = 0;
  int bad   = 0;
  logic [15:0] model;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  lbfp_acc #(.LANES(LANES), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_eop(in_eop), .tup_vld(tup_vld), .tup_len(tup_len),
    .fp_valid(fp_valid), .fp_ready(fp_ready), .fp_data(fp_data)
  );

  function automatic logic [15:0] bits_of(logic [LANES-1:0] v, logic [LANES*LEN_W-1:0] ls);
    logic [15:0] r = '0;
    for (int i = 0; i < LANES; i++) begin
      int len = int'(ls[i*LEN_W +: LEN_W]);
      if (v[i]) r = r | (16'd1 << ((len > 15) ? 15 : len));
    end
    return r;
  endfunction

  function automatic logic [31:0] nxt(logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one beat at negedge, check combinational outputs, then let the edge take it
  task automatic beat(string req, logic sop, logic eop,
                      logic [LANES-1:0] v, logic [LANES*LEN_W-1:0] ls);
    @(negedge clk);
    in_valid = 1'b1; in_sop = sop; in_eop = eop; tup_vld = v; tup_len = ls;
    if (sop) model = '0;
    model = model | bits_of(v, ls);
    #1;
    chk({req, "/R7 valid"}, 32'(fp_valid), 32'(eop));
    if (eop) chk(req, 32'(fp_data), 32'(model));
    @(posedge clk);
    if (eop && fp_ready) model = '0;
    #0.5;
    in_valid = 1'b0;
  endtask

  initial begin
    #190000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [LANES*LEN_W-1:0] ls;
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    tup_vld = '0; tup_len = '0; fp_ready = 1'b1; model = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle fp_valid", 32'(fp_valid), 0);
    chk("R1 idle in_ready", 32'(in_ready), 1);
    // R1: first packet without sop starts empty
    beat("R1 first pkt", 1'b0, 1'b1, 8'h01, 64'd7);

    // R2 / R3: every length on every lane
    for (int ln = 0; ln < LANES; ln++) begin
      for (int len = 0; len < 42; len++) begin
        ls = '0; ls[ln*LEN_W +: LEN_W] = LEN_W'(len);
        beat(len > 15 ? "R3 saturate" : "R2 bucket", 1'b1, 1'b1, LANES'(1) << ln, ls);
      end
      ls = '0; ls[ln*LEN_W +: LEN_W] = 8'hFF;
      beat("R3 max len", 1'b1, 1'b1, LANES'(1) << ln, ls);
    end

    // R4 / R10: all valid masks, invalid lanes hold distinct lengths
    for (int i = 0; i < LANES; i++) ls[i*LEN_W +: LEN_W] = LEN_W'(2*i + 1);
    for (int m = 0; m < 256; m++)
      beat(m == 0 ? "R10 empty" : "R4 mask", 1'b1, 1'b1, LANES'(m), ls);

    // R5: multi-beat packets with pseudo-random content
    for (int p = 0; p < 60; p++) begin
      int nb;
      seed = nxt(seed); nb = 1 + int'(seed[2:0] % 3'd6);
      for (int b = 0; b < nb; b++) begin
        seed = nxt(seed); ls[31:0] = seed;
        seed = nxt(seed); ls[63:32] = seed & 32'h1F1F_1F1F;
        seed = nxt(seed);
        beat("R5 multi", b == 0, b == nb - 1, seed[7:0] & seed[15:8], ls);
      end
      @(negedge clk);
      chk("R7 idle", 32'(fp_valid), 0);
    end

    // R6: sop mid-packet discards earlier beats
    beat("R6 pre", 1'b1, 1'b0, 8'h01, 64'd2);
    beat("R6 pre", 1'b0, 1'b0, 8'h01, 64'd9);
    beat("R6 restart", 1'b1, 1'b1, 8'h01, 64'd4);

    // R8: stalled closing beat keeps earlier buckets
    beat("R8 pre", 1'b1, 1'b0, 8'h03, {48'd0, 8'd1, 8'd3});
    beat("R8 pre", 1'b0, 1'b0, 8'h01, 64'd20);
    @(negedge clk);
    fp_ready = 1'b0;
    in_valid = 1'b1; in_sop = 1'b0; in_eop = 1'b1; tup_vld = 8'h01; tup_len = 64'd6;
    for (int s = 0; s < 4; s++) begin
      #1;
      chk("R8 in_ready low", 32'(in_ready), 0);
      chk("R8 held fp", 32'(fp_data), 32'h804A);
      @(negedge clk);
    end
    fp_ready = 1'b1;
    #1;
    chk("R8 release", 32'(fp_data), 32'h804A);
    chk("R8 release ready", 32'(in_ready), 1);
    @(posedge clk); #0.5; in_valid = 1'b0; model = '0;

    // R9: next packet starts empty without sop
    beat("R9 clear", 1'b0, 1'b1, 8'h02, {48'd0, 8'd11, 8'd0});

    // R1: reset mid-packet
    beat("R1 pre", 1'b1, 1'b0, 8'h01, 64'd13);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; model = '0;
    beat("R1 after reset", 1'b0, 1'b1, 8'h01, 64'd5);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule